// File: doc/BRIEF.md
# Four-Channel Match Timer

This block is a memory-mapped timer with four independent counters that share one prescaler. Each counter counts up or down on the prescaler's tick while its enable bit is set. It compares itself against its own match register. On a match it records a flag and can optionally return to zero, halt, or both. One interrupt line is raised while any flag whose interrupt enable is set is pending.

Software reaches every register through a synchronous bus with write strobe, read strobe, byte address and data. Each register occupies a 16-byte slot. The two address bits above the word offset select how a write is applied: a plain store, a bitwise OR, a bitwise AND-NOT or a bitwise XOR. This lets several agents change single bits without a read-modify-write sequence. Reads return data in the same cycle and do not depend on the alias bits.

Top module: `mtimer_top`

## Requirements
- R1: After reset, every register reads 0, the counters and the prescale counter are 0, and `irq` is low.
- R2: The slot index is `bus_addr[7:4]`: flags 0x0, control 0x1, direction 0x2, prescale limit 0x7, match control 0x9, match values 0xA to 0xD. The alias field is `bus_addr[3:2]`: 0 stores the data, 1 ORs it in, 2 clears the bits written as 1, and 3 inverts the bits written as 1. The new value is readable on the next cycle.
- R3: The counter slots 0x3 to 0x6 and the prescale counter slot 0x8 ignore writes at every alias. Flag bit 4 always reads 0.
- R4: While control bit 4+n is 1, counter n and the prescale counter read 0 and stay 0, even if the channel is enabled.
- R5: Direction field n sits at bits [4n+1:4n]. Code 00 counts up by one per tick and code 01 counts down by one per tick. Wrap-around in either direction sets no flag.
- R6: With prescale limit P, the prescale counter steps 0,1,…,P while any channel is enabled. It produces one tick for all enabled channels on the cycle it holds P, then restarts at 0. With P = 0 the counters advance every clock. While no channel is enabled, the prescale counter holds its value.
- R7: When an enabled counter equals match value n on a tick, flag n is set whether or not match-control bit 3n (interrupt enable) is 1. `irq` is high exactly while some flag n and bit 3n are both 1.
- R8: If match-control bit 3n+1 is set, a matching tick loads counter n with 0 instead of stepping it.
- R9: If match-control bit 3n+2 is set, a matching tick clears control bit n and counter n keeps the matched value.
- R10: A plain write to the flag slot clears each flag written as 1 and leaves flags written as 0 unchanged. A match in the same cycle as such a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address: slot in [7:4], alias in [3:2] |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, zero when `bus_rd` is low |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a flag clear that lands on the same clock edge as a new match, since both depend on exactly when the counter reaches its match value. The bench loads a small match value with return-to-zero. It counts clock edges from the enabling write, so the clearing write falls on the matching edge, then reads the flag back. The stop action and the prescaler phase are reached the same way, by counting edges, and the counter is frozen by disabling it before its value is read.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;
    localparam int NCH   = 4;
    localparam int DIR_FW = 4;
    localparam int ACT_W = 3;
    localparam int SELW  = $clog2(NCH);

    typedef enum logic [1:0] {
        AL_PLAIN = 2'd0,
        AL_SET   = 2'd1,
        AL_CLR   = 2'd2,
        AL_TOG   = 2'd3
    } alias_op_e;

    localparam logic [3:0] RI_FLAG = 4'd0;
    localparam logic [3:0] RI_CTRL = 4'd1;
    localparam logic [3:0] RI_DIR  = 4'd2;
    localparam logic [3:0] RI_CNT0 = 4'd3;
    localparam logic [3:0] RI_PRE  = 4'd7;
    localparam logic [3:0] RI_PCNT = 4'd8;
    localparam logic [3:0] RI_MCTL = 4'd9;
    localparam logic [3:0] RI_MV0  = 4'd10;
endpackage

// File: rtl/mtimer_prescaler.sv
module mtimer_prescaler #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic         tick,
    output logic [W-1:0] pcnt
);
    logic [W-1:0] pc_d, pc_q;

    assign tick = run && (pc_q >= limit);
    assign pcnt = pc_q;

    always_comb begin
        pc_d = pc_q;
        if (clr) begin
            pc_d = '0;
        end else if (run) begin
            pc_d = tick ? '0 : pc_q + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    // R6: a tick restarts the prescale count
    a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clr && tick) |=> (pcnt == '0));
    // R6: between ticks the prescale count steps by one
    a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clr && !tick) |=> (pcnt == $past(pcnt) + W'(1)));
    // R4: a channel reset clears the prescale count
    a_r4_pc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pcnt == '0));
endmodule

// File: rtl/mtimer_channel.sv
module mtimer_channel #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         en,
    input  logic         clr,
    input  logic         down,
    input  logic [W-1:0] mval,
    input  logic         act_rst,
    input  logic         act_stop,
    output logic [W-1:0] cnt,
    output logic         hit
);
    logic [W-1:0] cnt_d, cnt_q;

    assign cnt = cnt_q;
    assign hit = tick && en && !clr && (cnt_q == mval);

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (tick && en) begin
            if (hit && act_rst)       cnt_d = '0;
            else if (hit && act_stop) cnt_d = cnt_q;
            else if (down)            cnt_d = cnt_q - W'(1);
            else                      cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4: held reset keeps the counter at zero
    a_r4_clr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
    // R5: up counting steps by one per tick
    a_r5_up: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && en && !clr && !hit && !down) |=> (cnt == $past(cnt) + W'(1)));
    // R5: down counting steps by minus one per tick
    a_r5_down: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && en && !clr && !hit && down) |=> (cnt == $past(cnt) - W'(1)));
    // R8: match with return-to-zero action
    a_r8_match_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && act_rst) |=> (cnt == '0));
endmodule

// File: rtl/mtimer_top.sv
module mtimer_top
    import mtimer_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [7:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq
);
    localparam logic [3:0] RI_CNT_END = RI_CNT0 + 4'(NCH);
    localparam logic [3:0] RI_MV_END  = RI_MV0 + 4'(NCH);

    typedef struct packed {
        logic [NCH-1:0]          flag;
        logic [2*NCH-1:0]        ctrl;
        logic [DIR_FW*NCH-1:0]   dir;
        logic [DW-1:0]           presc;
        logic [ACT_W*NCH-1:0]    mctl;
        logic [NCH-1:0][DW-1:0]  mval;
    } regs_t;

    regs_t r_d, r_q;

    logic [3:0]              idx;
    alias_op_e               op;
    logic [SELW-1:0]         csel, msel;
    logic                    in_cnt, in_mv;
    logic [DW-1:0]           cur, nxt, rd_val;
    logic [NCH-1:0][DW-1:0]  cnt;
    logic [NCH-1:0]          hit, stop_hit, int_en;
    logic                    tick, any_en, any_clr;
    logic [DW-1:0]           pcnt;
    logic                    unused_lsb;

    assign idx        = bus_addr[7:4];
    assign op         = alias_op_e'(bus_addr[3:2]);
    assign unused_lsb = ^bus_addr[1:0];
    assign in_cnt     = (idx >= RI_CNT0) && (idx < RI_CNT_END);
    assign in_mv      = (idx >= RI_MV0) && (idx < RI_MV_END);
    assign csel       = SELW'(idx - RI_CNT0);
    assign msel       = SELW'(idx - RI_MV0);
    assign any_en     = |r_q.ctrl[NCH-1:0];
    assign any_clr    = |r_q.ctrl[2*NCH-1:NCH];

    function automatic logic [DW-1:0] alias_apply(alias_op_e o, logic [DW-1:0] c,
                                                  logic [DW-1:0] w);
        case (o)
            AL_PLAIN: return w;
            AL_SET:   return c | w;
            AL_CLR:   return c & ~w;
            default:  return c ^ w;
        endcase
    endfunction

    mtimer_prescaler #(.W(DW)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (any_en),
        .clr   (any_clr),
        .limit (r_q.presc),
        .tick  (tick),
        .pcnt  (pcnt)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        mtimer_channel #(.W(DW)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .en       (r_q.ctrl[n]),
            .clr      (r_q.ctrl[NCH+n]),
            .down     (r_q.dir[DIR_FW*n +: 2] == 2'b01),
            .mval     (r_q.mval[n]),
            .act_rst  (r_q.mctl[ACT_W*n+1]),
            .act_stop (r_q.mctl[ACT_W*n+2]),
            .cnt      (cnt[n]),
            .hit      (hit[n])
        );
        assign stop_hit[n] = hit[n] && r_q.mctl[ACT_W*n+2];
        assign int_en[n]   = r_q.mctl[ACT_W*n];

        // R9: a stopping match drops the channel enable
        a_r9_stop_clears_en: assert property (@(posedge clk) disable iff (!rst_n)
            stop_hit[n] |=> !r_q.ctrl[n]);
        // R10: a match always leaves its flag set, even against a clear
        a_r10_hit_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
            hit[n] |=> r_q.flag[n]);
    end

    always_comb begin
        cur = '0;
        case (idx)
            RI_FLAG: cur[NCH-1:0]          = r_q.flag;
            RI_CTRL: cur[2*NCH-1:0]        = r_q.ctrl;
            RI_DIR:  cur[DIR_FW*NCH-1:0]   = r_q.dir;
            RI_PRE:  cur                   = r_q.presc;
            RI_MCTL: cur[ACT_W*NCH-1:0]    = r_q.mctl;
            default: if (in_mv) cur = r_q.mval[msel];
        endcase
        nxt = alias_apply(op, cur, bus_wdata);

        r_d = r_q;
        if (bus_wr) begin
            case (idx)
                RI_FLAG: r_d.flag = (op == AL_PLAIN) ? (r_q.flag & ~bus_wdata[NCH-1:0])
                                                     : nxt[NCH-1:0];
                RI_CTRL: r_d.ctrl  = nxt[2*NCH-1:0];
                RI_DIR:  r_d.dir   = nxt[DIR_FW*NCH-1:0];
                RI_PRE:  r_d.presc = nxt;
                RI_MCTL: r_d.mctl  = nxt[ACT_W*NCH-1:0];
                default: if (in_mv) r_d.mval[msel] = nxt;
            endcase
        end
        r_d.flag           = r_d.flag | hit;
        r_d.ctrl[NCH-1:0]  = r_d.ctrl[NCH-1:0] & ~stop_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rd_val = '0;
        case (idx)
            RI_FLAG: rd_val[NCH-1:0]        = r_q.flag;
            RI_CTRL: rd_val[2*NCH-1:0]      = r_q.ctrl;
            RI_DIR:  rd_val[DIR_FW*NCH-1:0] = r_q.dir;
            RI_PRE:  rd_val                 = r_q.presc;
            RI_PCNT: rd_val                 = pcnt;
            RI_MCTL: rd_val[ACT_W*NCH-1:0]  = r_q.mctl;
            default: begin
                if (in_cnt)     rd_val = cnt[csel];
                else if (in_mv) rd_val = r_q.mval[msel];
            end
        endcase
    end

    assign bus_rdata = bus_rd ? rd_val : '0;
    assign irq       = |(r_q.flag & int_en);

    // R7: interrupt only with a pending, enabled flag
    a_r7_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|r_q.flag));
endmodule

// File: tb/tb_mtimer_top.sv
module tb_mtimer_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 53;

    typedef struct packed {
        logic [1:0]  kind;   // 0 write, 1 read check, 2 irq check
        logic [3:0]  req;
        logic [7:0]  addr;
        logic [31:0] data;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        {2'd0, 4'd2, 8'h20, 32'h0000_1111}, {2'd1, 4'd2, 8'h20, 32'h0000_1111},
        {2'd0, 4'd2, 8'h24, 32'h0000_0220}, {2'd1, 4'd2, 8'h20, 32'h0000_1331},
        {2'd0, 4'd2, 8'h28, 32'h0000_0101}, {2'd1, 4'd2, 8'h20, 32'h0000_1230},
        {2'd0, 4'd2, 8'h2C, 32'h0000_FFFF}, {2'd1, 4'd2, 8'h20, 32'h0000_EDCF},
        {2'd0, 4'd2, 8'h20, 32'h0000_0000}, {2'd1, 4'd2, 8'h20, 32'h0000_0000},
        {2'd0, 4'd2, 8'h70, 32'hF0F0_0000}, {2'd0, 4'd2, 8'h74, 32'h0000_00FF},
        {2'd1, 4'd2, 8'h70, 32'hF0F0_00FF}, {2'd0, 4'd2, 8'h78, 32'hF000_0000},
        {2'd1, 4'd2, 8'h70, 32'h00F0_00FF}, {2'd0, 4'd2, 8'h7C, 32'hFFFF_FFFF},
        {2'd1, 4'd2, 8'h70, 32'hFF0F_FF00}, {2'd0, 4'd2, 8'h70, 32'h0000_0000},
        {2'd0, 4'd2, 8'h90, 32'h0000_0ABC}, {2'd1, 4'd2, 8'h90, 32'h0000_0ABC},
        {2'd0, 4'd2, 8'h9C, 32'h0000_0FFF}, {2'd1, 4'd2, 8'h90, 32'h0000_0543},
        {2'd0, 4'd2, 8'h90, 32'h0000_0000}, {2'd0, 4'd2, 8'hA0, 32'h1111_1111},
        {2'd0, 4'd2, 8'hD4, 32'h8000_0000}, {2'd1, 4'd2, 8'hA0, 32'h1111_1111},
        {2'd1, 4'd2, 8'hD0, 32'h8000_0000}, {2'd0, 4'd3, 8'h30, 32'h0000_0055},
        {2'd0, 4'd3, 8'h34, 32'h0000_00FF}, {2'd1, 4'd3, 8'h30, 32'h0000_0000},
        {2'd0, 4'd3, 8'h84, 32'h0000_00FF}, {2'd1, 4'd3, 8'h80, 32'h0000_0000},
        {2'd0, 4'd3, 8'h04, 32'h0000_001F}, {2'd1, 4'd3, 8'h00, 32'h0000_000F},
        {2'd2, 4'd7, 8'h00, 32'h0000_0000}, {2'd0, 4'd7, 8'h90, 32'h0000_0001},
        {2'd2, 4'd7, 8'h00, 32'h0000_0001}, {2'd0, 4'd10, 8'h00, 32'h0000_0000},
        {2'd1, 4'd10, 8'h00, 32'h0000_000F}, {2'd0, 4'd10, 8'h00, 32'h0000_0005},
        {2'd1, 4'd10, 8'h00, 32'h0000_000A}, {2'd2, 4'd7, 8'h00, 32'h0000_0000},
        {2'd0, 4'd2, 8'h0C, 32'h0000_0003}, {2'd1, 4'd2, 8'h00, 32'h0000_0009},
        {2'd2, 4'd7, 8'h00, 32'h0000_0001}, {2'd0, 4'd2, 8'h08, 32'h0000_000F},
        {2'd1, 4'd2, 8'h00, 32'h0000_0000}, {2'd2, 4'd7, 8'h00, 32'h0000_0000},
        {2'd0, 4'd2, 8'h90, 32'h0000_0000}, {2'd0, 4'd4, 8'h10, 32'h0000_00F0},
        {2'd1, 4'd4, 8'h10, 32'h0000_00F0}, {2'd0, 4'd4, 8'h18, 32'h0000_00F0},
        {2'd1, 4'd4, 8'h10, 32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mtimer_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic expect_reg(string req, logic [7:0] a, logic [31:0] exp);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
        bus_rd = 1'b0;
    endtask

    task automatic expect_irq(string req, logic exp);
        @(negedge clk);
        #1;
        check(req, {31'd0, irq}, {31'd0, exp});
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        expect_irq("R1 irq", 1'b0);
        expect_reg("R1 flags", 8'h00, 32'h0);
        expect_reg("R1 ctrl", 8'h10, 32'h0);
        expect_reg("R1 dir", 8'h20, 32'h0);
        expect_reg("R1 cnt0", 8'h30, 32'h0);
        expect_reg("R1 cnt3", 8'h60, 32'h0);
        expect_reg("R1 prescale", 8'h70, 32'h0);
        expect_reg("R1 pcount", 8'h80, 32'h0);
        expect_reg("R1 matchctl", 8'h90, 32'h0);
        expect_reg("R1 match0", 8'hA0, 32'h0);

        // Vector walk: aliases (R2), read-only slots (R3), flags (R10), irq gating (R7)
        for (int i = 0; i < NV; i++) begin
            case (VEC[i].kind)
                2'd0: bus_write(VEC[i].addr, VEC[i].data);
                2'd1: expect_reg($sformatf("R%0d vec %0d", VEC[i].req, i), VEC[i].addr, VEC[i].data);
                default: expect_irq($sformatf("R%0d vec %0d", VEC[i].req, i), VEC[i].data[0]);
            endcase
        end

        // R5/R6: count up with prescale 0 over five enabled edges
        bus_write(8'h14, 32'h01);
        idle(3);
        bus_write(8'h18, 32'h01);
        expect_reg("R5 up count", 8'h30, 32'd5);
        expect_reg("R5 no flag", 8'h00, 32'h0);

        // R4: held reset keeps counter at zero even while enabled
        bus_write(8'h14, 32'h10);
        expect_reg("R4 cnt0 cleared", 8'h30, 32'h0);
        expect_reg("R4 reset bit holds", 8'h10, 32'h10);
        bus_write(8'h14, 32'h01);
        idle(3);
        expect_reg("R4 cnt0 held", 8'h30, 32'h0);
        bus_write(8'h18, 32'h11);

        // R5: down count wraps below zero without flag
        bus_write(8'h20, 32'h10);
        bus_write(8'hB0, 32'd5);
        bus_write(8'h14, 32'h02);
        bus_write(8'h18, 32'h02);
        expect_reg("R5 down wrap", 8'h40, 32'hFFFF_FFFE);
        expect_reg("R5 wrap no flag", 8'h00, 32'h0);
        bus_write(8'h14, 32'h20);
        bus_write(8'h18, 32'h20);
        expect_reg("R4 cnt1 cleared", 8'h40, 32'h0);
        bus_write(8'h20, 32'h0);

        // R6: prescale limit 2 gives one tick per three enabled edges
        bus_write(8'h70, 32'd2);
        bus_write(8'hC0, 32'h0000_FFFF);
        bus_write(8'h14, 32'h04);
        idle(8);
        bus_write(8'h18, 32'h04);
        expect_reg("R6 prescaled count", 8'h50, 32'd3);
        expect_reg("R6 prescale phase", 8'h80, 32'd1);
        bus_write(8'h70, 32'd0);
        bus_write(8'h14, 32'h40);
        bus_write(8'h18, 32'h40);
        expect_reg("R4 pcount cleared", 8'h80, 32'h0);

        // R8/R7: match 3 with return-to-zero and interrupt enable
        bus_write(8'hA0, 32'd3);
        bus_write(8'h90, 32'h003);
        bus_write(8'h14, 32'h01);
        idle(3);
        bus_write(8'h18, 32'h01);
        expect_reg("R8 zero after match", 8'h30, 32'd1);
        expect_reg("R7 flag0 set", 8'h00, 32'h1);
        expect_irq("R7 irq on enabled flag", 1'b1);
        bus_write(8'h00, 32'h1);
        expect_irq("R10 irq after clear", 1'b0);

        // R10: clear lands on the matching edge; flag must survive
        bus_write(8'h14, 32'h10);
        bus_write(8'h18, 32'h10);
        bus_write(8'h14, 32'h01);
        idle(2);
        bus_write(8'h00, 32'h1);
        bus_write(8'h18, 32'h01);
        expect_reg("R10 match beats clear", 8'h00, 32'h1);
        expect_reg("R8 count after collision", 8'h30, 32'd2);
        bus_write(8'h00, 32'h1);
        expect_reg("R10 clear alone", 8'h00, 32'h0);

        // R9: stop on match 4, interrupt not enabled
        bus_write(8'hD0, 32'd4);
        bus_write(8'h90, 32'h800);
        bus_write(8'h14, 32'h08);
        idle(6);
        expect_reg("R9 enable dropped", 8'h10, 32'h0);
        expect_reg("R9 count held", 8'h60, 32'd4);
        expect_reg("R7 flag3 without int enable", 8'h00, 32'h8);
        expect_irq("R7 no irq without enable", 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule